// File: doc/BRIEF.md
# DMA Address and Count Register

This block keeps the programmable state of a single DMA channel. It holds a 14-bit transfer count, a direction flag, an enable flag and a 22-bit word-aligned memory address. The CPU programs all of them through register writes. A count write takes its value from the data bus. An address write takes its value from the CPU address lines of the write cycle, not from the data bus. Word-address bit 14 of that cycle picks which half of the DMA address is replaced.

The DMA engine pulses a transfer-done strobe once per moved word. Each accepted strobe steps the address forward by one word and counts the count down by one. When the count reaches zero, a terminal-count flag is raised, and the block ignores further strobes until software writes the count again. A count readback word is also provided for the CPU's register read path.

Top module: `dma_xfer_regs`

## Requirements
- R1: After reset, dmaAddr, dmaCount, xferDir and xferEnable are all zero and termCount is 1.
- R2: A count write stores (cntWrData[13:0] + 1) modulo 2^14 as the count, cntWrData[14] as xferDir and cntWrData[15] as xferEnable, visible on the outputs one cycle later. A written 0x3FFF therefore yields count 0.
- R3: countReadback always equals {2'b11, dmaCount}.
- R4: An address write with cpuWordAddr[14] = 1 loads dmaAddr[21:9] from cpuWordAddr[13:1] and leaves dmaAddr[8:1] unchanged.
- R5: An address write with cpuWordAddr[14] = 0 loads dmaAddr[8:1] from cpuWordAddr[8:1] and leaves dmaAddr[21:9] unchanged. cpuWordAddr[13:9] is ignored in this case.
- R6: dmaAddr[0] is always 0.
- R7: A transfer-done strobe that is accepted adds 2 to dmaAddr (wrapping modulo 2^22) and subtracts 1 from the count. It leaves xferDir and xferEnable unchanged.
- R8: termCount is 1 exactly when the count is 0. While the count is 0, transfer-done strobes change neither the address nor the count.
- R9: A transfer-done strobe in the same cycle as any register write is dropped. Only the write takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cntWrEn | input | 1 | Count register write strobe |
| cntWrData | input | 16 | Data bus value of the count write |
| addrWrEn | input | 1 | Address register write strobe |
| cpuWordAddr | input | 14 | CPU address bits 14:1 of the address write |
| xferDone | input | 1 | One word transferred by the DMA engine |
| dmaAddr | output | 22 | Current DMA byte address, word aligned |
| dmaCount | output | 14 | Remaining transfer count |
| countReadback | output | 16 | Count register read value |
| xferDir | output | 1 | Transfer direction flag |
| xferEnable | output | 1 | Transfer enable flag |
| termCount | output | 1 | Count has reached zero |

## Verification
A wrong half select or a wrong kept-bit mask shows up on dmaAddr in the cycle right after the address write. A lost or doubled step shows on dmaAddr and dmaCount one cycle after the strobe. It then stays visible, because nothing corrects it until the next write. A faulty terminal-count gate lets the count wrap from zero to 0x3FFF and the address creep on. The bench sees this on the first ignored strobe. Same-cycle collisions between a write and a strobe are compared in the cycle after the collision.

// File: rtl/dma_regs_pkg.sv
package dma_regs_pkg;

  // Strobes from the control decoder to the register datapath
  typedef struct packed {
    logic loadCnt;
    logic loadHi;
    logic loadLo;
    logic step;
  } ctlStrobes_t;

endpackage

// File: rtl/dma_ctl.sv
module dma_ctl
  import dma_regs_pkg::*;
#(
  parameter int SEL_BIT = 14
) (
  input  logic        cntWrEn,
  input  logic        addrWrEn,
  input  logic        addrHalfSel,
  input  logic        xferDone,
  input  logic        termCount,
  output ctlStrobes_t strobes
);

  always_comb begin
    strobes.loadCnt = cntWrEn;
    // word-address bit SEL_BIT picks the upper half when high
    strobes.loadHi  = addrWrEn & addrHalfSel;
    strobes.loadLo  = addrWrEn & ~addrHalfSel;
    // any write in the same cycle drops the strobe (R9); count zero blocks it (R8)
    strobes.step    = xferDone & ~cntWrEn & ~addrWrEn & ~termCount;
  end

endmodule

// File: rtl/dma_dp.sv
module dma_dp
  import dma_regs_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 22,
  parameter int LO_TOP = 8,
  localparam int CNT_W = DATA_W - 2,
  localparam int HI_W  = ADDR_W - 1 - LO_TOP
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctlStrobes_t       strobes,
  input  logic [DATA_W-1:0] cntData,
  input  logic [HI_W-1:0]   hiSrc,
  input  logic [LO_TOP-1:0] loSrc,
  output logic [ADDR_W-1:0] addrQ,
  output logic [CNT_W-1:0]  cntQ,
  output logic              dirQ,
  output logic              enQ,
  output logic              termCount
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cntQ <= '0;
      dirQ <= 1'b0;
      enQ  <= 1'b0;
    end else if (strobes.loadCnt) begin
      cntQ <= cntData[CNT_W-1:0] + CNT_W'(1);
      dirQ <= cntData[CNT_W];
      enQ  <= cntData[CNT_W+1];
    end else if (strobes.step) begin
      cntQ <= cntQ - CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addrQ <= '0;
    end else if (strobes.loadHi) begin
      addrQ[ADDR_W-1:LO_TOP+1] <= hiSrc;
    end else if (strobes.loadLo) begin
      addrQ[LO_TOP:1] <= loSrc;
    end else if (strobes.step) begin
      addrQ <= addrQ + ADDR_W'(2);
    end
  end

  assign termCount = (cntQ == '0);

  p_load_cnt_r2: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.loadCnt |=> cntQ == CNT_W'($past(cntData[CNT_W-1:0]) + CNT_W'(1)));

  p_hi_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.loadHi |=> addrQ[LO_TOP:1] == $past(addrQ[LO_TOP:1]));

  p_lo_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.loadLo |=> addrQ[ADDR_W-1:LO_TOP+1] == $past(addrQ[ADDR_W-1:LO_TOP+1]));

  p_word_align_r6: assert property (@(posedge clk) disable iff (!rst_n)
    addrQ[0] == 1'b0);

  p_step_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.step |=> addrQ == ADDR_W'($past(addrQ) + ADDR_W'(2)));

  p_step_cnt_r7: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.step |=> cntQ == CNT_W'($past(cntQ) - CNT_W'(1)) && $stable(dirQ) && $stable(enQ));

  p_tc_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cntQ == '0 && !strobes.loadCnt && !strobes.loadHi && !strobes.loadLo)
      |=> $stable(cntQ) && $stable(addrQ));

endmodule

// File: rtl/dma_xfer_regs.sv
module dma_xfer_regs
  import dma_regs_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 22,
  parameter int LO_TOP = 8,
  localparam int CNT_W   = DATA_W - 2,
  localparam int HI_W    = ADDR_W - 1 - LO_TOP,
  localparam int SEL_BIT = HI_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cntWrEn,
  input  logic [DATA_W-1:0]  cntWrData,
  input  logic               addrWrEn,
  input  logic [SEL_BIT:1]   cpuWordAddr,
  input  logic               xferDone,
  output logic [ADDR_W-1:0]  dmaAddr,
  output logic [CNT_W-1:0]   dmaCount,
  output logic [DATA_W-1:0]  countReadback,
  output logic               xferDir,
  output logic               xferEnable,
  output logic               termCount
);

  ctlStrobes_t strobes;

  dma_ctl #(.SEL_BIT(SEL_BIT)) u_ctl (
    .cntWrEn     (cntWrEn),
    .addrWrEn    (addrWrEn),
    .addrHalfSel (cpuWordAddr[SEL_BIT]),
    .xferDone    (xferDone),
    .termCount   (termCount),
    .strobes     (strobes)
  );

  dma_dp #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .LO_TOP(LO_TOP)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobes   (strobes),
    .cntData   (cntWrData),
    .hiSrc     (cpuWordAddr[HI_W:1]),
    .loSrc     (cpuWordAddr[LO_TOP:1]),
    .addrQ     (dmaAddr),
    .cntQ      (dmaCount),
    .dirQ      (xferDir),
    .enQ       (xferEnable),
    .termCount (termCount)
  );

  // upper two readback bits read as ones (R3)
  assign countReadback = {2'b11, dmaCount};

endmodule

// File: tb/sim_dma_xfer_regs.sv
`timescale 1ns/1ps
module sim_dma_xfer_regs;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cntWrEn = 1'b0;
  logic [15:0] cntWrData = '0;
  logic        addrWrEn = 1'b0;
  logic [14:1] cpuWordAddr = '0;
  logic        xferDone = 1'b0;
  logic [21:0] dmaAddr;
  logic [13:0] dmaCount;
  logic [15:0] countReadback;
  logic        xferDir, xferEnable, termCount;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int mAddr = 0, mCnt = 0, mDir = 0, mEn = 0;

  always #2 clk = ~clk;

  dma_xfer_regs u0 (
    .clk(clk), .rst_n(rst_n), .cntWrEn(cntWrEn), .cntWrData(cntWrData),
    .addrWrEn(addrWrEn), .cpuWordAddr(cpuWordAddr), .xferDone(xferDone),
    .dmaAddr(dmaAddr), .dmaCount(dmaCount), .countReadback(countReadback),
    .xferDir(xferDir), .xferEnable(xferEnable), .termCount(termCount)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic compareAll(input string tag);
    check(tag, "dmaAddr", int'(dmaAddr), mAddr);
    check(tag, "dmaCount", int'(dmaCount), mCnt);
    check(tag, "xferDir", int'(xferDir), mDir);
    check(tag, "xferEnable", int'(xferEnable), mEn);
    check("R3", "countReadback", int'(countReadback), 32'hC000 | mCnt);
    check("R6", "dmaAddr[0]", int'(dmaAddr[0]), 0);
    check("R8", "termCount", int'(termCount), (mCnt == 0) ? 1 : 0);
  endtask

  // drive one cycle of stimulus, advance the model, compare after the edge
  task automatic tick(input bit cw, input int cd, input bit aw, input int wa,
                      input bit dn, input string tag);
    int a;
    cntWrEn = cw; cntWrData = 16'(cd); addrWrEn = aw;
    cpuWordAddr = 14'(wa >> 1); xferDone = dn;
    @(posedge clk);
    if (cw) begin
      mCnt = ((cd & 'h3FFF) + 1) & 'h3FFF;
      mDir = (cd >> 14) & 1;
      mEn  = (cd >> 15) & 1;
    end
    a = wa & 'h7FFF;
    if (aw) begin
      if (a & 'h4000) mAddr = (mAddr & 'h1FE) | (((a >> 1) & 'h1FFF) << 9);
      else            mAddr = (mAddr & 'h3FFE00) | (a & 'h1FE);
    end
    if (dn && !cw && !aw && mCnt != 0) begin
      mAddr = (mAddr + 2) & 'h3FFFFF;
      mCnt  = mCnt - 1;
    end
    @(negedge clk);
    cntWrEn = 1'b0; addrWrEn = 1'b0; xferDone = 1'b0;
    compareAll(tag);
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected under 20000", cycles);
      finishRun();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    compareAll("R1");
    tick(0, 0, 0, 0, 1, "R8");                   // strobe at count zero after reset
    tick(1, 'h8005, 0, 0, 0, "R2");              // enable, dir 0, count 6
    tick(0, 0, 1, 'h4000 | ('h1ABC << 1), 0, "R4");
    tick(0, 0, 1, 'h3FFF, 0, "R5");              // bits 13:9 set but ignored
    tick(0, 0, 1, 'h7FFE, 0, "R4");
    tick(0, 0, 1, 'h0024, 0, "R5");
    for (int i = 0; i < 6; i++) tick(0, 0, 0, 0, 1, "R7");
    for (int i = 0; i < 3; i++) tick(0, 0, 0, 0, 1, "R8");
    tick(1, 'h4003, 0, 0, 1, "R9");              // write wins over strobe
    tick(0, 0, 0, 0, 1, "R7");
    tick(0, 0, 1, 'h0100, 1, "R9");              // address write drops strobe
    tick(0, 0, 1, 'h4000 | ('h0055 << 1), 1, "R9");
    tick(1, 'hFFFF, 0, 0, 0, "R2");              // 0x3FFF + 1 wraps to zero
    tick(0, 0, 0, 0, 1, "R8");
    tick(0, 0, 1, 'h7FFE, 0, "R4");              // address to top of range
    tick(0, 0, 1, 'h01FE, 0, "R5");
    tick(1, 'h0001, 0, 0, 0, "R2");
    tick(0, 0, 0, 0, 1, "R7");                   // wraps to zero
    tick(0, 0, 0, 0, 1, "R7");
    tick(0, 0, 0, 0, 1, "R8");
    for (int i = 0; i < 20; i++)
      tick(i % 5 == 0, 'h0010 + i, i % 7 == 3, (i * 'h2A6) & 'h7FFE, 1, "R7");
    rst_n = 1'b0;
    @(posedge clk);
    mAddr = 0; mCnt = 0; mDir = 0; mEn = 0;
    @(negedge clk);
    rst_n = 1'b1;
    compareAll("R1");
    finishRun();
  end

endmodule